// File: doc/BRIEF.md
# Load/Store Address Unit with Alignment and Illegal-Form Traps

This block executes one decoded memory operation at a time on a 16-bit machine. It computes the effective address and reads the address and data registers through three read ports. It then issues one or two word accesses on a simple memory port. Loaded data goes back to the register file, followed by any address-register update. Operations are 16-bit words or 32-bit register pairs.

Six addressing forms are recognised. Three leave the address register unchanged: register, register plus displacement, and absolute. Two update it after the access: post-increment and post-decrement. The sixth is a stack push, which only stores: it decrements register 15, writes memory at the new address, and then writes that address back to register 15. When the modulo-enable bit of the status word is set, post-updates wrap between a start bound and an end bound.

Two kinds of fault produce a trap. An odd effective address raises an address trap: the block saves PC and the status word into backup registers, strips the status word down to its flag bits and jumps to a vector. An illegal operation form raises an illegal trap and leaves everything untouched, PC included.

Top module: `lsu_addr_trap`

## Requirements
- R1: The mode field `op_mode` selects the effective address (EA), with all arithmetic modulo 2^16. 0 gives Ra. 1 gives Ra+disp. 2 gives disp. 3 (post-increment) and 4 (post-decrement) give Ra. 5 (push) gives R15-2 for a word or R15-4 for a pair. Ra is the register named by `op_areg`, and `op_areg` is ignored in mode 5.
- R2: An EA with bit 0 set raises `trap_ae` for one cycle. That operation issues no `mem_req` and no `rf_we`.
- R3: On an address trap, `bpc_wdata` equals the PC and `bpsw_wdata` equals the status word, both as captured at acceptance. `psw_wdata` keeps only bits 15 (F0), 14 (F1) and 0 (carry) and clears all others. `pc_wdata` equals `AE_VECTOR` (default 16'h3FFC). All four write enables pulse together in that cycle.
- R4: Post-increment adds 2 for a word and 4 for a pair. Post-decrement subtracts the same amounts.
- R5: With status bit 7 (modulo enable) set, a post-update first compares Ra with `mod_end`, masking bit 0 for a word or bits 1:0 for a pair. On a match Ra is reloaded with `mod_start` instead of being stepped.
- R6: A post-update load skips the Ra update in two cases. For a word load, the skip happens when the destination equals Ra. For a pair load, it happens when either register of the pair equals Ra.
- R7: A pair uses the even register (index with bit 0 cleared) at EA and the odd register at EA+2. This layout holds for both loads and stores.
- R8: Three forms are illegal: mode 6 or 7, mode 5 on a load, and a mode 4 store with `op_areg`=15. Each raises `trap_ill` for one cycle, with no memory access, no register write and no PC, status or backup write.
- R9: A push writes memory before it writes R15, and R15 receives the EA. A push whose EA is odd traps and writes nothing.
- R10: `op_ready` is high only when the block is idle. An operation is accepted on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is low in the next cycle, and the first access is issued in that cycle.
- R11: A pair store issues two word writes on consecutive cycles. The alignment check happens before the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Block idle, operation accepted this edge |
| op_store | input | 1 | 1 = store, 0 = load |
| op_dword | input | 1 | 1 = register pair, 0 = word |
| op_mode | input | 3 | Addressing form (see R1) |
| op_dreg | input | 4 | Data register (pair: bit 0 ignored) |
| op_areg | input | 4 | Address register |
| op_disp | input | 16 | Displacement or absolute address |
| rf_a_idx | output | 4 | Address register read index |
| rf_a_data | input | 16 | Address register value |
| rf_b_idx | output | 4 | Data (even) register read index |
| rf_b_data | input | 16 | Data (even) register value |
| rf_c_idx | output | 4 | Odd pair register read index |
| rf_c_data | input | 16 | Odd pair register value |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 16 | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| mod_start | input | 16 | Modulo reload value |
| mod_end | input | 16 | Modulo end value |
| pc_in | input | 16 | Current PC |
| psw_in | input | 16 | Current status word |
| pc_we | output | 1 | PC write enable |
| pc_wdata | output | 16 | New PC |
| psw_we | output | 1 | Status word write enable |
| psw_wdata | output | 16 | New status word |
| bpc_we | output | 1 | Backup PC write enable |
| bpc_wdata | output | 16 | Backup PC value |
| bpsw_we | output | 1 | Backup status write enable |
| bpsw_wdata | output | 16 | Backup status value |
| trap_ae | output | 1 | Address trap pulse |
| trap_ill | output | 1 | Illegal-form trap pulse |

## Verification
Random operations run against a register-file and memory model. Roughly half the generated addresses are odd, so trapped and completed operations are compared on the same state. The modulo end value is often set to the address register's own value, which separates the wrap path from the plain step. Loads whose destination overlaps the address register show whether the update is suppressed. Directed cases cover the forms a random mix hits rarely: a pair store split across two writes, the ordering of the push and a push to an odd address, a post-decrement store through R15, a push coded as a load, and a displacement that wraps past 16 bits.

// File: rtl/lsu_pkg.sv
// Shared constants and types for the load/store address unit.
// Assumes a 16-register file with 16-bit registers and register 15 as stack pointer.
package lsu_pkg;
    localparam int unsigned XLEN    = 16;
    localparam int unsigned RIDX_W  = 4;
    localparam int unsigned MODE_W  = 3;

    localparam logic [MODE_W-1:0] AM_REG   = 3'd0;
    localparam logic [MODE_W-1:0] AM_DISP  = 3'd1;
    localparam logic [MODE_W-1:0] AM_ABS   = 3'd2;
    localparam logic [MODE_W-1:0] AM_PINC  = 3'd3;
    localparam logic [MODE_W-1:0] AM_PDEC  = 3'd4;
    localparam logic [MODE_W-1:0] AM_PUSH  = 3'd5;

    localparam logic [RIDX_W-1:0] SP_IDX   = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC0,
        ST_ACC1,
        ST_UPD,
        ST_TRAP_AE,
        ST_TRAP_ILL
    } lsu_state_e;
endpackage

// File: rtl/lsu_ea_calc.sv
// Effective-address former and form checker.
// Purely combinational; assumes register values are already read for this operation.
module lsu_ea_calc
    import lsu_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              is_store,
    input  logic              is_dword,
    input  logic [RIDX_W-1:0] areg_idx,
    input  logic [XLEN-1:0]   areg_val,
    input  logic [XLEN-1:0]   disp,
    output logic [XLEN-1:0]   ea,
    output logic              illegal,
    output logic              misaligned,
    output logic              post_step
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(2);
    localparam logic [XLEN-1:0] PAIR_BYTES = XLEN'(4);

    logic [XLEN-1:0] push_step;

    // Size of the stack decrement for a push
    always_comb push_step = is_dword ? PAIR_BYTES : WORD_BYTES;

    // Address selection per mode, wrapping modulo 2^XLEN
    always_comb begin
        unique case (mode)
            AM_DISP: ea = areg_val + disp;
            AM_ABS:  ea = disp;
            AM_PUSH: ea = areg_val - push_step;
            default: ea = areg_val;
        endcase
    end

    // Illegal forms: unused codes, push as load, post-decrement store through SP
    always_comb begin
        illegal = (mode > AM_PUSH)
                | ((mode == AM_PUSH) & ~is_store)
                | ((mode == AM_PDEC) & is_store & (areg_idx == SP_IDX));
    end

    // Odd final address and post-update classification
    always_comb begin
        misaligned = ea[0];
        post_step  = (mode == AM_PINC) | (mode == AM_PDEC);
    end
endmodule

// File: rtl/lsu_mod_step.sv
// Address-register post-update with optional circular wrap.
// Combinational; assumes the caller decides whether the result is written.
module lsu_mod_step
    import lsu_pkg::*;
(
    input  logic            is_dword,
    input  logic            is_dec,
    input  logic            wrap_en,
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] mod_start,
    input  logic [XLEN-1:0] mod_end,
    output logic [XLEN-1:0] nxt
);
    localparam logic [XLEN-1:0] MASK_WORD = ~XLEN'(1);
    localparam logic [XLEN-1:0] MASK_PAIR = ~XLEN'(3);

    logic [XLEN-1:0] step;
    logic [XLEN-1:0] end_masked;
    logic            hit_end;

    // Step size and end-bound mask follow the access size
    always_comb begin
        step       = is_dword ? XLEN'(4) : XLEN'(2);
        end_masked = mod_end & (is_dword ? MASK_PAIR : MASK_WORD);
        hit_end    = wrap_en & (cur == end_masked);
    end

    // Reload from start bound on a hit, otherwise step
    always_comb begin
        if (hit_end)     nxt = mod_start;
        else if (is_dec) nxt = cur - step;
        else             nxt = cur + step;
    end
endmodule

// File: rtl/lsu_trap_gen.sv
// Address-trap entry values: backups, masked status word and vector.
// Combinational; assumes its inputs are the state captured at acceptance.
module lsu_trap_gen
    import lsu_pkg::*;
#(
    parameter logic [XLEN-1:0] KEEP_MASK = 16'hC001,
    parameter logic [XLEN-1:0] VECTOR    = 16'h3FFC
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] psw_cur,
    output logic [XLEN-1:0] bpc_val,
    output logic [XLEN-1:0] bpsw_val,
    output logic [XLEN-1:0] psw_val,
    output logic [XLEN-1:0] pc_val
);
    // Save, mask and redirect
    always_comb begin
        bpc_val  = pc_cur;
        bpsw_val = psw_cur;
        psw_val  = psw_cur & KEEP_MASK;
        pc_val   = VECTOR;
    end
endmodule

// File: rtl/lsu_addr_trap.sv
// Load/store address unit top: accepts one decoded operation, sequences
// word accesses, write-back and address update, or raises a trap.
// Assumes register reads and memory reads return data in the same cycle.
module lsu_addr_trap
    import lsu_pkg::*;
#(
    parameter int unsigned     PSW_MODEN_BIT = 7,
    parameter int unsigned     PSW_F0_BIT    = 15,
    parameter int unsigned     PSW_F1_BIT    = 14,
    parameter int unsigned     PSW_CY_BIT    = 0,
    parameter logic [XLEN-1:0] AE_VECTOR     = 16'h3FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic              op_dword,
    input  logic [MODE_W-1:0] op_mode,
    input  logic [RIDX_W-1:0] op_dreg,
    input  logic [RIDX_W-1:0] op_areg,
    input  logic [XLEN-1:0]   op_disp,
    output logic [RIDX_W-1:0] rf_a_idx,
    input  logic [XLEN-1:0]   rf_a_data,
    output logic [RIDX_W-1:0] rf_b_idx,
    input  logic [XLEN-1:0]   rf_b_data,
    output logic [RIDX_W-1:0] rf_c_idx,
    input  logic [XLEN-1:0]   rf_c_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_widx,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic [XLEN-1:0]   mod_start,
    input  logic [XLEN-1:0]   mod_end,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   psw_in,
    output logic              pc_we,
    output logic [XLEN-1:0]   pc_wdata,
    output logic              psw_we,
    output logic [XLEN-1:0]   psw_wdata,
    output logic              bpc_we,
    output logic [XLEN-1:0]   bpc_wdata,
    output logic              bpsw_we,
    output logic [XLEN-1:0]   bpsw_wdata,
    output logic              trap_ae,
    output logic              trap_ill
);
    localparam logic [XLEN-1:0] KEEP_MASK = (XLEN'(1) << PSW_F0_BIT)
                                          | (XLEN'(1) << PSW_F1_BIT)
                                          | (XLEN'(1) << PSW_CY_BIT);

    lsu_state_e state, state_nx;

    logic            accept;
    logic [XLEN-1:0] ea;
    logic            ill, misal, post_step;
    logic [XLEN-1:0] stepped;
    logic [XLEN-1:0] upd_val;
    logic            overlap;
    logic            upd_req;

    logic [XLEN-1:0]   r_ea, r_upd_val, r_wd0, r_wd1, r_pc, r_psw;
    logic [RIDX_W-1:0] r_dlo, r_dhi, r_areg;
    logic              r_store, r_dword, r_upd;

    // Register read indices straight from the decoded operation
    always_comb begin
        rf_a_idx = (op_mode == AM_PUSH) ? SP_IDX : op_areg;
        rf_b_idx = op_dword ? {op_dreg[RIDX_W-1:1], 1'b0} : op_dreg;
        rf_c_idx = {op_dreg[RIDX_W-1:1], 1'b1};
    end

    lsu_ea_calc u_ea (
        .mode       (op_mode),
        .is_store   (op_store),
        .is_dword   (op_dword),
        .areg_idx   (op_areg),
        .areg_val   (rf_a_data),
        .disp       (op_disp),
        .ea         (ea),
        .illegal    (ill),
        .misaligned (misal),
        .post_step  (post_step)
    );

    lsu_mod_step u_step (
        .is_dword  (op_dword),
        .is_dec    (op_mode == AM_PDEC),
        .wrap_en   (psw_in[PSW_MODEN_BIT]),
        .cur       (rf_a_data),
        .mod_start (mod_start),
        .mod_end   (mod_end),
        .nxt       (stepped)
    );

    // Update decision: push always writes SP; loads skip on destination overlap
    always_comb begin
        accept  = op_valid & (state == ST_IDLE);
        overlap = op_dword ? (op_dreg[RIDX_W-1:1] == rf_a_idx[RIDX_W-1:1])
                           : (op_dreg == rf_a_idx);
        upd_req = (op_mode == AM_PUSH) | (post_step & (op_store | ~overlap));
        upd_val = (op_mode == AM_PUSH) ? ea : stepped;
    end

    // Sequencer next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (ill)        state_nx = ST_TRAP_ILL;
                else if (misal) state_nx = ST_TRAP_AE;
                else            state_nx = ST_ACC0;
            end
            ST_ACC0: begin
                if (r_dword)    state_nx = ST_ACC1;
                else if (r_upd) state_nx = ST_UPD;
                else            state_nx = ST_IDLE;
            end
            ST_ACC1: state_nx = r_upd ? ST_UPD : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operation context captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_ea      <= '0;
            r_upd_val <= '0;
            r_wd0     <= '0;
            r_wd1     <= '0;
            r_pc      <= '0;
            r_psw     <= '0;
            r_dlo     <= '0;
            r_dhi     <= '0;
            r_areg    <= '0;
            r_store   <= 1'b0;
            r_dword   <= 1'b0;
            r_upd     <= 1'b0;
        end else if (accept) begin
            r_ea      <= ea;
            r_upd_val <= upd_val;
            r_wd0     <= rf_b_data;
            r_wd1     <= rf_c_data;
            r_pc      <= pc_in;
            r_psw     <= psw_in;
            r_dlo     <= rf_b_idx;
            r_dhi     <= rf_c_idx;
            r_areg    <= rf_a_idx;
            r_store   <= op_store;
            r_dword   <= op_dword;
            r_upd     <= upd_req;
        end
    end

    // Memory port: first word at EA, second at EA+2
    always_comb begin
        mem_req   = (state == ST_ACC0) | (state == ST_ACC1);
        mem_we    = mem_req & r_store;
        mem_addr  = (state == ST_ACC1) ? (r_ea + XLEN'(2)) : r_ea;
        mem_wdata = (state == ST_ACC1) ? r_wd1 : r_wd0;
    end

    // Register write port: load data during access, address update afterwards
    always_comb begin
        rf_we    = (mem_req & ~r_store) | (state == ST_UPD);
        rf_widx  = (state == ST_UPD) ? r_areg : ((state == ST_ACC1) ? r_dhi : r_dlo);
        rf_wdata = (state == ST_UPD) ? r_upd_val : mem_rdata;
    end

    lsu_trap_gen #(
        .KEEP_MASK (KEEP_MASK),
        .VECTOR    (AE_VECTOR)
    ) u_trap (
        .pc_cur   (r_pc),
        .psw_cur  (r_psw),
        .bpc_val  (bpc_wdata),
        .bpsw_val (bpsw_wdata),
        .psw_val  (psw_wdata),
        .pc_val   (pc_wdata)
    );

    // Handshake and trap strobes
    always_comb begin
        op_ready = (state == ST_IDLE);
        trap_ae  = (state == ST_TRAP_AE);
        trap_ill = (state == ST_TRAP_ILL);
        pc_we    = trap_ae;
        psw_we   = trap_ae;
        bpc_we   = trap_ae;
        bpsw_we  = trap_ae;
    end
endmodule

// File: rtl/lsu_addr_trap_chk.sv
// Property checker for lsu_addr_trap, bound to every instance.
// Assumes the default status-word flag positions and vector.
module lsu_addr_trap_chk #(
    parameter logic [15:0] KEEP_MASK = 16'hC001,
    parameter logic [15:0] AE_VECTOR = 16'h3FFC
) (
    input logic        clk,
    input logic        rst_n,
    input logic        op_ready,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        rf_we,
    input logic        pc_we,
    input logic [15:0] pc_wdata,
    input logic        psw_we,
    input logic [15:0] psw_wdata,
    input logic        bpc_we,
    input logic        bpsw_we,
    input logic        trap_ae,
    input logic        trap_ill
);
    a_r2_no_access_on_ae: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ae |-> (!mem_req && !rf_we));

    a_r2_even_bus: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    a_r3_entry_writes: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ae |-> (pc_we && psw_we && bpc_we && bpsw_we && pc_wdata == AE_VECTOR));

    a_r3_psw_masked: assert property (@(posedge clk) disable iff (!rst_n)
        psw_we |-> ((psw_wdata & ~KEEP_MASK) == 16'h0000));

    a_r8_ill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ill |-> (!mem_req && !rf_we && !pc_we && !psw_we));

    a_r10_busy_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || trap_ae || trap_ill) |-> !op_ready);

    a_r10_single_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, trap_ae, trap_ill}));
endmodule

bind lsu_addr_trap lsu_addr_trap_chk u_chk (.*);

// File: tb/lsu_addr_trap_tb.sv
`timescale 1ns/1ps
module lsu_addr_trap_tb;
    localparam logic [15:0] KEEP = 16'hC001;
    localparam logic [15:0] VEC  = 16'h3FFC;
    localparam int          MDB  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        op_valid = 1'b0, op_store = 1'b0, op_dword = 1'b0;
    logic [2:0]  op_mode = '0;
    logic [3:0]  op_dreg = '0, op_areg = '0;
    logic [15:0] op_disp = '0;
    logic        op_ready;
    logic [3:0]  rf_a_idx, rf_b_idx, rf_c_idx, rf_widx;
    logic [15:0] rf_a_data, rf_b_data, rf_c_data, rf_wdata;
    logic        rf_we, mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] mod_start = '0, mod_end = '0;
    logic        pc_we, psw_we, bpc_we, bpsw_we, trap_ae, trap_ill;
    logic [15:0] pc_wdata, psw_wdata, bpc_wdata, bpsw_wdata;

    logic [15:0] d_rf [16];
    logic [15:0] d_mem [256];
    logic [15:0] d_pc, d_psw, d_bpc, d_bpsw;
    logic        pk_rf = 1'b0, pk_psw = 1'b0;
    logic [3:0]  pk_idx = '0;
    logic [15:0] pk_val = '0;
    int          cyc = 0, mem_wr_cnt = 0, acc_cnt = 0, rfw_cnt = 0, ae_cnt = 0, ill_cnt = 0;
    int          last_mem_cyc = 0, last_sp_cyc = 0;

    logic [15:0] m_rf [16];
    logic [15:0] m_mem [256];
    logic [15:0] m_pc, m_psw, m_bpc, m_bpsw;
    bit          e_ae, e_ill;

    int tests = 0, fails = 0;

    assign rf_a_data = d_rf[rf_a_idx];
    assign rf_b_data = d_rf[rf_b_idx];
    assign rf_c_data = d_rf[rf_c_idx];
    assign mem_rdata = d_mem[mem_addr[8:1]];

    lsu_addr_trap u_dut (.*, .pc_in(d_pc), .psw_in(d_psw));

    function automatic logic [15:0] init_rf(int i);
        return 16'(i * 16'h1234 + 16'h0100);
    endfunction
    function automatic logic [15:0] init_mem(int i);
        return 16'(i * 16'h9E37) ^ 16'h5A5A;
    endfunction

    // Bench-side register file, memory and control registers
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) d_rf[i] <= init_rf(i);
            for (int i = 0; i < 256; i++) d_mem[i] <= init_mem(i);
            d_pc <= 16'h0100; d_psw <= 16'hC0A5; d_bpc <= '0; d_bpsw <= '0;
        end else begin
            if (pk_rf) d_rf[pk_idx] <= pk_val;
            if (pk_psw) d_psw <= pk_val;
            if (mem_req) acc_cnt <= acc_cnt + 1;
            if (mem_req && mem_we) begin
                d_mem[mem_addr[8:1]] <= mem_wdata;
                mem_wr_cnt <= mem_wr_cnt + 1;
                last_mem_cyc <= cyc;
            end
            if (rf_we) begin
                d_rf[rf_widx] <= rf_wdata;
                rfw_cnt <= rfw_cnt + 1;
                if (rf_widx == 4'd15) last_sp_cyc <= cyc;
            end
            if (pc_we) d_pc <= pc_wdata;
            if (psw_we) d_psw <= psw_wdata;
            if (bpc_we) d_bpc <= bpc_wdata;
            if (bpsw_we) d_bpsw <= bpsw_wdata;
            if (trap_ae) ae_cnt <= ae_cnt + 1;
            if (trap_ill) ill_cnt <= ill_cnt + 1;
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected result of one operation, from the requirements
    task automatic model(logic [2:0] md, bit st, bit dw, logic [3:0] dr, logic [3:0] ar, logic [15:0] disp);
        logic [3:0]  ai = (md == 3'd5) ? 4'd15 : ar;
        logic [15:0] av = m_rf[ai];
        logic [15:0] ea, nx, stp, emask;
        logic [3:0]  lo, hi;
        logic [15:0] v0, v1, s0, s1;
        bit          ovl;
        e_ae = 0; e_ill = 0;
        stp = dw ? 16'd4 : 16'd2;
        case (md)
            3'd1: ea = av + disp;
            3'd2: ea = disp;
            3'd5: ea = av - stp;
            default: ea = av;
        endcase
        if (md > 3'd5 || (md == 3'd5 && !st) || (md == 3'd4 && st && ar == 4'd15)) begin
            e_ill = 1; return;
        end
        if (ea[0]) begin
            e_ae = 1; m_bpc = m_pc; m_bpsw = m_psw; m_psw = m_psw & KEEP; m_pc = VEC;
            return;
        end
        lo = dw ? {dr[3:1], 1'b0} : dr; hi = {dr[3:1], 1'b1};
        s0 = m_rf[lo]; s1 = m_rf[hi];
        v0 = m_mem[ea[8:1]]; v1 = m_mem[16'(ea + 16'd2) >> 1 & 16'hFF];
        if (st) begin
            m_mem[ea[8:1]] = s0;
            if (dw) m_mem[16'(ea + 16'd2) >> 1 & 16'hFF] = s1;
        end else begin
            m_rf[lo] = v0;
            if (dw) m_rf[hi] = v1;
        end
        ovl = dw ? (dr[3:1] == ai[3:1]) : (dr == ai);
        if (md == 3'd5) m_rf[15] = ea;
        else if ((md == 3'd3 || md == 3'd4) && (st || !ovl)) begin
            emask = mod_end & (dw ? 16'hFFFC : 16'hFFFE);
            if (m_psw[MDB] && av == emask) nx = mod_start;
            else nx = (md == 3'd4) ? av - stp : av + stp;
            m_rf[ai] = nx;
        end
    endtask

    task automatic poke_reg(logic [3:0] i, logic [15:0] v);
        @(negedge clk); pk_rf = 1; pk_idx = i; pk_val = v;
        @(negedge clk); pk_rf = 0;
        m_rf[i] = v;
    endtask

    task automatic poke_psw(logic [15:0] v);
        @(negedge clk); pk_psw = 1; pk_val = v;
        @(negedge clk); pk_psw = 0;
        m_psw = v;
    endtask

    // Issue one operation, wait for idle, compare against the model
    task automatic do_op(logic [2:0] md, bit st, bit dw, logic [3:0] dr, logic [3:0] ar,
                         logic [15:0] disp, string req);
        int ae0 = ae_cnt, il0 = ill_cnt, acc0 = acc_cnt, rw0 = rfw_cnt, n = 0;
        bit rf_ok = 1, mem_ok = 1;
        @(negedge clk);
        op_valid = 1; op_mode = md; op_store = st; op_dword = dw;
        op_dreg = dr; op_areg = ar; op_disp = disp;
        model(md, st, dw, dr, ar, disp);
        @(negedge clk);
        op_valid = 0;
        check(!op_ready, "R10", "busy after accept", 32'(op_ready), 0);
        while (!op_ready && n < 20) begin @(negedge clk); n++; end
        check((ae_cnt - ae0) == int'(e_ae) && (ill_cnt - il0) == int'(e_ill) &&
              (!(e_ae || e_ill) || (acc_cnt == acc0 && rfw_cnt == rw0)),
              e_ill ? "R8" : (e_ae ? "R2" : req), "trap/quiet",
              {ae_cnt - ae0, ill_cnt - il0}, {16'(e_ae), 16'(e_ill)});
        for (int i = 0; i < 16; i++) if (d_rf[i] !== m_rf[i]) rf_ok = 0;
        for (int i = 0; i < 256; i++) if (d_mem[i] !== m_mem[i]) mem_ok = 0;
        check(rf_ok, req, "register file", 32'(d_rf[op_areg]), 32'(m_rf[op_areg]));
        check(mem_ok, req, "memory", 0, 0);
        check(d_pc == m_pc && d_psw == m_psw && d_bpc == m_bpc && d_bpsw == m_bpsw,
              e_ae ? "R3" : req, "pc/psw/bpc/bpsw",
              {d_pc, d_psw}, {m_pc, m_psw});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w0;
        void'($urandom(32'h1BADCAFE));
        for (int i = 0; i < 16; i++) m_rf[i] = init_rf(i);
        for (int i = 0; i < 256; i++) m_mem[i] = init_mem(i);
        m_pc = 16'h0100; m_psw = 16'hC0A5; m_bpc = '0; m_bpsw = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(op_ready && !mem_req && !trap_ae && !trap_ill && !rf_we, "R10",
              "reset idle", {op_ready, mem_req, trap_ae, trap_ill}, 32'h8);

        // R1: displacement wraps past 16 bits
        poke_reg(4'd2, 16'hFFF0);
        do_op(3'd1, 1'b0, 1'b0, 4'd3, 4'd2, 16'h0014, "R1");
        // R2: odd EA after displacement
        do_op(3'd1, 1'b1, 1'b0, 4'd3, 4'd2, 16'h0013, "R2");
        // R7 R11: pair store layout, two consecutive writes
        poke_reg(4'd6, 16'h0080);
        w0 = mem_wr_cnt;
        do_op(3'd0, 1'b1, 1'b1, 4'd9, 4'd6, 16'h0, "R7");
        check(mem_wr_cnt - w0 == 2, "R11", "pair write count", 32'(mem_wr_cnt - w0), 2);
        // R7: pair load back into another pair
        do_op(3'd0, 1'b0, 1'b1, 4'd10, 4'd6, 16'h0, "R7");
        // R4: post-increment and post-decrement, both sizes
        poke_psw(16'h0000);
        poke_reg(4'd5, 16'h0200);
        do_op(3'd3, 1'b1, 1'b0, 4'd1, 4'd5, 16'h0, "R4");
        do_op(3'd3, 1'b1, 1'b1, 4'd0, 4'd5, 16'h0, "R4");
        do_op(3'd4, 1'b0, 1'b1, 4'd8, 4'd5, 16'h0, "R4");
        // R5: modulo wrap on a masked end match
        poke_psw(16'h0080);
        mod_start = 16'h0010; mod_end = 16'h0043;
        poke_reg(4'd4, 16'h0040);
        do_op(3'd3, 1'b1, 1'b1, 4'd2, 4'd4, 16'h0, "R5");
        check(d_rf[4] == 16'h0010, "R5", "wrapped register", 32'(d_rf[4]), 32'h10);
        // R6: load destination overlapping the address register
        poke_reg(4'd7, 16'h0060);
        do_op(3'd3, 1'b0, 1'b1, 4'd6, 4'd7, 16'h0, "R6");
        // R8: illegal forms
        do_op(3'd4, 1'b1, 1'b0, 4'd1, 4'd15, 16'h0, "R8");
        do_op(3'd5, 1'b0, 1'b0, 4'd1, 4'd0, 16'h0, "R8");
        do_op(3'd7, 1'b1, 1'b0, 4'd1, 4'd2, 16'h0, "R8");
        // R9: push order and odd push
        poke_reg(4'd15, 16'h0100);
        do_op(3'd5, 1'b1, 1'b1, 4'd2, 4'd0, 16'h0, "R9");
        check(last_mem_cyc < last_sp_cyc, "R9", "memory before SP",
              32'(last_mem_cyc), 32'(last_sp_cyc));
        poke_reg(4'd15, 16'h0101);
        do_op(3'd5, 1'b1, 1'b0, 4'd2, 4'd0, 16'h0, "R9");

        // Random mix (R1..R6 behaviour), with frequent modulo end hits
        for (int k = 0; k < 300; k++) begin
            logic [3:0]  ar = 4'($urandom % 16);
            logic [3:0]  md = 4'($urandom % 16);
            logic [2:0]  mode = (md < 4'd14) ? 3'(md % 6) : 3'(6 + (md & 1));
            if ($urandom % 8 == 0) poke_psw(16'($urandom));
            if ($urandom % 3 == 0) mod_end = m_rf[(mode == 3'd5) ? 4'd15 : ar] | 16'($urandom % 4);
            mod_start = 16'($urandom) & 16'hFFFE;
            do_op(mode, 1'($urandom), 1'($urandom), 4'($urandom), ar,
                  16'($urandom) & (($urandom % 2) ? 16'hFFFE : 16'hFFFF), "R1");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule